// File: doc/BRIEF.md
# Transition-Statistics Carrier Detector

This block judges whether a demodulator is receiving a real data carrier by looking at when its hard-decision output changes. On every qualified sample it records whether the bit flipped and, in the default scoring mode, rewards or penalises each flip according to how far it lies from the flips before it. Flips that arrive one sample after another, or that follow a long quiet stretch, look like noise and push the score up. Flips spaced two to four samples apart look like oversampled symbols and pull it down. Scores are collected over fixed intervals. At the end of each interval the block compares the sum of the three most recent interval scores against zero and registers the result as the carrier flag.

A squelch mode suits receivers that mute their audio when no signal is present. It charges one point per flip and uses a much shorter interval. An external mode ignores the scores for the decision and instead samples a carrier pin at each interval end, with selectable polarity. Reading the scores lets the surrounding logic tune thresholds or watch the channel.

Top module: `carrier_detect`

## Requirements
- R1: The mode input selects scoring: 0 = soft, 1 = squelch, 2 or 3 = external.
- R1: In soft mode, a flip (rx_bit differing from the previously accepted sample) adds 16*P - N to score0.
  - Bit 0 of the history is the newest flip flag, and bit k is the flag from k samples earlier.
  - P is history bit 1, plus 2 when history bits 1 to 30 are all zero.
  - N is the sum of history bits 2, 3 and 4.
- R2: In squelch and external modes, each flip lowers score0 by exactly 1.
- R3: score0 saturates at the limits of a signed SCORE_W-bit value and never wraps.
- R4: An interval ends on every SOFT_LEN-th accepted sample in soft mode and every SQL_LEN-th in the other modes, counted from reset or the last mode change. The carrier flag changes only at an interval end.
- R5: In soft and squelch modes, the interval end sets carrier to (score0 + score1 + score2) < 0. Here score0 already includes the flip of the closing sample.
- R6: At an interval end, score2 takes score1, score1 takes the updated score0, and score0 is preset to +2, so a silent input yields no carrier.
- R7: In external mode, the interval end sets carrier to ext_cd XOR ext_inv.
- R8: A change of mode takes effect on the next clock edge and replaces that edge's sample. On that edge:
  - the history is cleared and rx_bit is captured as the previous sample;
  - score0 becomes 2, score1 and score2 become 0, and carrier is cleared;
  - the interval restarts at the new mode's length.
- R9: With sample_en low, the scores and the carrier hold their values.
- R10: Reset leaves carrier 0, score0 = 2, score1 = score2 = 0, and soft mode with a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Accept rx_bit as a new sample on this edge |
| rx_bit | input | 1 | Hard-decision demodulator output |
| mode | input | 2 | 0 soft, 1 squelch, 2/3 external |
| ext_cd | input | 1 | External carrier pin |
| ext_inv | input | 1 | Invert ext_cd |
| carrier | output | 1 | Registered carrier-detect flag |
| score0 | output | SCORE_W | Current interval score, signed |
| score1 | output | SCORE_W | Previous interval score, signed |
| score2 | output | SCORE_W | Score from two intervals back, signed |

## Verification
Every output is a register, so a sample or mode change presented before a rising edge shows its full effect right after that edge. This applies to the score update, the interval-end shift and the carrier decision alike. The bench drives inputs on the falling edge, advances its own model of the requirements for the coming rising edge, and compares all four outputs at the next falling edge. Any output that changes one edge early or late therefore shows up as a miscompare in that very cycle. Directed phases check the following at known interval boundaries:
- saturation;
- a silent channel;
- flips spaced three samples apart;
- a mode change.

// File: rtl/carrier_detect.sv
module carrier_detect #(
  parameter int HIST_W   = 32,
  parameter int SCORE_W  = 16,
  parameter int SOFT_LEN = 240,
  parameter int SQL_LEN  = 12,
  parameter int PRESET   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_en,
  input  logic                      rx_bit,
  input  logic [1:0]                mode,
  input  logic                      ext_cd,
  input  logic                      ext_inv,
  output logic                      carrier,
  output logic signed [SCORE_W-1:0] score0,
  output logic signed [SCORE_W-1:0] score1,
  output logic signed [SCORE_W-1:0] score2
);
  localparam int KEEP   = HIST_W - 2;
  localparam int MAXLEN = (SOFT_LEN > SQL_LEN) ? SOFT_LEN : SQL_LEN;
  localparam int CNT_W  = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
  localparam int SUM_W  = SCORE_W + 2;
  localparam logic signed [SCORE_W:0] SMAX = (SCORE_W+1)'(2**(SCORE_W-1) - 1);
  localparam logic signed [SCORE_W:0] SMIN = -SMAX - 1;
  localparam logic [1:0] M_SOFT = 2'd0;

  logic [1:0]        mode_q;
  logic              last_bit;
  logic [KEEP-1:0]   hist;
  logic [CNT_W-1:0]  cnt;

  wire               mode_chg = (mode != mode_q);
  wire [KEEP:0]      hist_n   = {hist, rx_bit ^ last_bit};
  wire               iso      = (hist_n[KEEP:1] == '0);
  wire [1:0]         pos      = {iso, hist_n[1]};
  wire [1:0]         neg      = {1'b0, hist_n[2]} + {1'b0, hist_n[3]} + {1'b0, hist_n[4]};
  wire               at_end   = (cnt == '0);

  logic signed [7:0]         delta;
  logic signed [SCORE_W:0]   dext, s0x, wide;
  logic signed [SCORE_W-1:0] s0n;
  logic signed [SUM_W-1:0]   sum;

  always_comb begin
    delta = '0;
    if (hist_n[0]) begin
      if (mode_q == M_SOFT) delta = $signed({2'b00, pos, 4'b0000}) - $signed({6'b0, neg});
      else                  delta = -8'sd1;
    end
  end

  assign dext = delta;
  assign s0x  = score0;
  assign wide = s0x + dext;
  assign s0n  = (wide > SMAX) ? SMAX[SCORE_W-1:0] :
                (wide < SMIN) ? SMIN[SCORE_W-1:0] : wide[SCORE_W-1:0];
  assign sum  = SUM_W'(s0n) + SUM_W'(score1) + SUM_W'(score2);

  function automatic logic [CNT_W-1:0] reload(input logic [1:0] m);
    return (m == M_SOFT) ? CNT_W'(SOFT_LEN - 1) : CNT_W'(SQL_LEN - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_SOFT;
      last_bit <= 1'b0;
      hist     <= '0;
      cnt      <= CNT_W'(SOFT_LEN - 1);
      score0   <= SCORE_W'(PRESET);
      score1   <= '0;
      score2   <= '0;
      carrier  <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= mode;
      last_bit <= rx_bit;
      hist     <= '0;
      cnt      <= reload(mode);
      score0   <= SCORE_W'(PRESET);
      score1   <= '0;
      score2   <= '0;
      carrier  <= 1'b0;
    end else if (sample_en) begin
      last_bit <= rx_bit;
      hist     <= hist_n[KEEP-1:0];
      if (at_end) begin
        carrier <= mode_q[1] ? (ext_cd ^ ext_inv) : (sum < 0);
        score2  <= score1;
        score1  <= s0n;
        score0  <= SCORE_W'(PRESET);
        cnt     <= reload(mode_q);
      end else begin
        score0  <= s0n;
        cnt     <= cnt - 1'b1;
      end
    end
  end

  a_r6_shift_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !mode_chg && at_end) |=> (score0 == SCORE_W'(PRESET)) && (score2 == $past(score1)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !mode_chg) |=> $stable(score0) && $stable(score1) && $stable(score2) && $stable(carrier));

  a_r8_mode_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (score0 == SCORE_W'(PRESET)) && (score1 == '0) && (score2 == '0) && !carrier);

  a_r2_squelch_down: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !mode_chg && !at_end && mode_q != M_SOFT) |=> (score0 <= $past(score0)));

  a_r4_carrier_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && !(sample_en && at_end)) |=> $stable(carrier));

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAXLEN - 1));

  a_r7_external: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !mode_chg && at_end && mode_q[1]) |=> (carrier == $past(ext_cd ^ ext_inv)));
endmodule

// File: tb/tb_carrier_detect.sv
module tb_carrier_detect;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 10;
  localparam int SOFT = 240;
  localparam int SQL  = 12;
  localparam int SMAX = 2**(SW-1) - 1;
  localparam int SMIN = -(2**(SW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0, rx_bit = 1'b0, ext_cd = 1'b0, ext_inv = 1'b0;
  logic [1:0] mode = 2'd0;
  logic carrier;
  logic signed [SW-1:0] score0, score1, score2;

  carrier_detect #(.SCORE_W(SW), .SOFT_LEN(SOFT), .SQL_LEN(SQL)) dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_bit(rx_bit), .mode(mode),
    .ext_cd(ext_cd), .ext_inv(ext_inv), .carrier(carrier),
    .score0(score0), .score1(score1), .score2(score2));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R10";

  logic [1:0]  m_mode;
  logic        m_last, m_cd;
  logic [31:0] m_hist;
  int          m_cnt, m_s0, m_s1, m_s2;

  function automatic int sat(input int v);
    return (v > SMAX) ? SMAX : (v < SMIN) ? SMIN : v;
  endfunction

  function automatic int len_of(input logic [1:0] m);
    return (m == 2'd0) ? SOFT : SQL;
  endfunction

  task automatic model_reset();
    m_mode = 2'd0; m_last = 1'b0; m_hist = '0; m_cnt = SOFT - 1;
    m_s0 = 2; m_s1 = 0; m_s2 = 0; m_cd = 1'b0;
  endtask

  task automatic model_step();
    logic [31:0] hn;
    int d, p, n, s0n;
    if (mode != m_mode) begin
      m_mode = mode; m_last = rx_bit; m_hist = '0; m_cnt = len_of(mode) - 1;
      m_s0 = 2; m_s1 = 0; m_s2 = 0; m_cd = 1'b0;
    end else if (sample_en) begin
      hn = {m_hist[30:0], rx_bit ^ m_last};
      d = 0;
      if (hn[0]) begin
        if (m_mode == 2'd0) begin
          p = int'(hn[1]) + ((hn[30:1] == '0) ? 2 : 0);
          n = int'(hn[2]) + int'(hn[3]) + int'(hn[4]);
          d = 16*p - n;
        end else d = -1;
      end
      s0n = sat(m_s0 + d);
      if (m_cnt == 0) begin
        m_cd = m_mode[1] ? (ext_cd ^ ext_inv) : ((s0n + m_s1 + m_s2) < 0);
        m_s2 = m_s1; m_s1 = s0n; m_s0 = 2; m_cnt = len_of(m_mode) - 1;
      end else begin
        m_s0 = s0n; m_cnt--;
      end
      m_hist = hn; m_last = rx_bit;
    end
  endtask

  task automatic check_int(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check_int("carrier", int'(carrier), int'(m_cd));
    check_int("score0", int'(score0), m_s0);
    check_int("score1", int'(score1), m_s1);
    check_int("score2", int'(score2), m_s2);
  endtask

  task automatic tick(input bit se, input bit rb, input logic [1:0] md, input bit ec, input bit ei);
    sample_en = se; rx_bit = rb; mode = md; ext_cd = ec; ext_inv = ei;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R10";
    compare();
    check_int("reset score0 preset", int'(score0), 2);
    rst_n = 1'b1;

    tag = "R1 R4 R5 R6 R9 soft random";
    for (int i = 0; i < 3000; i++)
      tick(($urandom % 4) != 0, $urandom % 2, 2'd0, 1'b0, 1'b0);

    tag = "R3 saturation";
    for (int i = 0; i < 100; i++) tick(1'b1, i[0], 2'd0, 1'b0, 1'b0);
    check_int("R3 score0 pinned at max", int'(score0), SMAX);

    tag = "R6 silent channel";
    for (int i = 0; i < 3*SOFT + 5; i++) tick(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    check_int("R6 silent carrier", int'(carrier), 0);

    tag = "R1 R5 spacing three";
    for (int i = 0; i < 3*SOFT + 3; i++) tick(1'b1, ((i / 3) % 2) == 1, 2'd0, 1'b0, 1'b0);
    check_int("R5 spaced flips give carrier", int'(carrier), 1);

    tag = "R8 mode change";
    tick(1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
    check_int("R8 carrier cleared", int'(carrier), 0);
    check_int("R8 score1 cleared", int'(score1), 0);

    tag = "R2 R4 squelch random";
    for (int i = 0; i < 600; i++)
      tick(($urandom % 3) != 0, $urandom % 2, 2'd1, 1'b0, 1'b0);

    tag = "R2 R4 squelch quiet";
    for (int i = 0; i < 3*SQL + 1; i++) tick(1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
    check_int("R6 squelch quiet carrier", int'(carrier), 0);

    tag = "R7 external";
    for (int i = 0; i < 800; i++)
      tick(($urandom % 4) != 0, $urandom % 2, (i < 400) ? 2'd2 : 2'd3,
           ((i / 17) % 2) == 1, i >= 250 && i < 600);

    tag = "R7 external directed";
    for (int i = 0; i < SQL; i++) tick(1'b1, 1'b0, 2'd3, 1'b0, 1'b1);
    check_int("R7 inverted low pin", int'(carrier), 1);

    tag = "R8 R1 back to soft";
    for (int i = 0; i < 1500; i++)
      tick(($urandom % 5) != 0, (($urandom % 4) == 0) ? ~rx_bit : rx_bit, 2'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule